// File: doc/BRIEF.md
# Tag-Matching Reservation Station

This block holds decoded operations that are waiting for their source operands, and releases each one to an execution port as soon as both operands are present. Every slot keeps two sources, and each source is either a value captured at write time or the tag of the producer that will supply it. Result buses carry a tag and a value. Every waiting source compares its tag against every bus in the same cycle, and on a hit it takes the value and becomes ready.

Up to three operations are written per cycle. An allocation port is asserted only while at least three slots are free. Each operation names the port class it must run on. Each cycle, every port issues the oldest ready slot of its own class, so operations leave out of program order whenever an older one is still waiting. A flush empties the whole station in one cycle.

Top module: `rs_wakeup_select`

## Requirements
- R1: After reset the station is empty: no port issues and `alloc_rdy` is 1.
- R2: `alloc_rdy` is 1 exactly when at least ALLOC (3) slots are free. Allocation requests made while it is 0 are dropped and never issue.
- R3: An operation written with both sources ready can issue in the cycle after the write. It presents its opcode, both captured values and its reorder tag.
- R4: A waiting source whose tag equals the tag on a valid result bus captures that bus value. The slot can issue in the cycle after the broadcast, not in the broadcast cycle.
- R5: A result broadcast in the same cycle that an operation is written is matched against the incoming not-ready sources, so the wakeup is not lost.
- R6: Among the ready slots of one class, the oldest issues first. Allocation order sets the age. Within one cycle, a lower allocation lane is older than a higher one.
- R7: Port p issues only operations whose class field equals p (1-bit class, 0 or 1). The two ports can issue in the same cycle.
- R8: Each port issues at most one operation per cycle. An issued operation leaves the station and is never issued again.
- R9: A flush removes every slot in the next cycle and drops any allocation requested in the flush cycle.
- R10: Both result buses may wake the two sources of one slot in the same cycle.
- R11: A broadcast whose tag matches no waiting source changes nothing: the waiting slot stays unissued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Empties the station |
| alloc_vld | input | ALLOC | Per-lane write request |
| alloc_op | input | ALLOC x OPW | Opcode per lane |
| alloc_cls | input | ALLOC x CLSW | Execution port class per lane |
| alloc_rob | input | ALLOC x ROBW | Reorder tag per lane |
| alloc_a_rdy | input | ALLOC | Source A holds a value |
| alloc_a_tag | input | ALLOC x TAGW | Source A producer tag |
| alloc_a_val | input | ALLOC x DW | Source A value |
| alloc_b_rdy | input | ALLOC | Source B holds a value |
| alloc_b_tag | input | ALLOC x TAGW | Source B producer tag |
| alloc_b_val | input | ALLOC x DW | Source B value |
| alloc_rdy | output | 1 | Room for a full allocation group |
| res_vld | input | NBC | Result bus valid |
| res_tag | input | NBC x TAGW | Result bus tag |
| res_val | input | NBC x DW | Result bus value |
| iss_vld | output | PORTS | Issue valid per port |
| iss_op | output | PORTS x OPW | Issued opcode |
| iss_src_a | output | PORTS x DW | Issued source A value |
| iss_src_b | output | PORTS x DW | Issued source B value |
| iss_rob | output | PORTS x ROBW | Issued reorder tag |

## Verification
Two pairs of events can share a cycle. A result broadcast can coincide with an allocation whose sources wait on that tag. Two age-ordered slots can also become ready in the same cycle, when one broadcast wakes an older slot while a younger one is already waiting on another tag. Directed sequences set up both cases, including both buses waking one slot and a three-lane group becoming ready together. Random traffic with a small tag space then makes them frequent. A bench model tracks waiting operations by allocation sequence number and predicts every issue and `alloc_rdy` value cycle by cycle.

// File: rtl/rs_pkg.sv
package rs_pkg;
  // Default geometry of the station
  localparam int RS_ENTRIES = 8;
  localparam int RS_ALLOC   = 3;
  localparam int RS_PORTS   = 2;
  localparam int RS_NBC     = 2;
  localparam int RS_DW      = 16;
  localparam int RS_TAGW    = 5;
  localparam int RS_OPW     = 4;
  localparam int RS_ROBW    = 5;

  // Width of the port-class field for a given port count
  function automatic int cls_width(int ports);
    return (ports > 1) ? $clog2(ports) : 1;
  endfunction
endpackage

// File: rtl/rs_capture.sv
// Associative match of one source operand against all result buses.
module rs_capture #(
  parameter int NBC  = 2,
  parameter int TAGW = 5,
  parameter int DW   = 16
) (
  input  logic                      in_rdy,
  input  logic [TAGW-1:0]           in_tag,
  input  logic [DW-1:0]             in_val,
  input  logic [NBC-1:0]            bc_vld,
  input  logic [NBC-1:0][TAGW-1:0]  bc_tag,
  input  logic [NBC-1:0][DW-1:0]    bc_val,
  output logic                      out_rdy,
  output logic [DW-1:0]             out_val
);
  always_comb begin
    out_rdy = in_rdy;
    out_val = in_val;
    for (int b = 0; b < NBC; b++) begin
      if (!in_rdy && bc_vld[b] && (bc_tag[b] == in_tag)) begin
        out_rdy = 1'b1;
        out_val = bc_val[b];
      end
    end
  end
endmodule

// File: rtl/rs_alloc_pick.sv
// Finds free slots and hands the n-th free slot to allocation lane n.
module rs_alloc_pick #(
  parameter int ENTRIES = 8,
  parameter int ALLOC   = 3
) (
  input  logic [ENTRIES-1:0]            busy,
  input  logic [ALLOC-1:0]              req,
  input  logic                          block,
  output logic                          alloc_rdy,
  output logic [ALLOC-1:0][ENTRIES-1:0] gnt
);
  function automatic int free_count(logic [ENTRIES-1:0] v);
    int n = 0;
    for (int i = 0; i < ENTRIES; i++) if (!v[i]) n++;
    return n;
  endfunction

  logic room;
  assign room      = free_count(busy) >= ALLOC;
  assign alloc_rdy = room;

  always_comb begin
    int nth;
    nth = 0;
    gnt = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (!busy[e]) begin
        for (int k = 0; k < ALLOC; k++) begin
          if (nth == k && req[k] && room && !block) gnt[k][e] = 1'b1;
        end
        nth++;
      end
    end
  end
endmodule

// File: rtl/rs_age_pick.sv
// Age matrix plus per-port oldest-ready selection.
// older_q[i][j] = 1 means slot j was written before slot i.
module rs_age_pick #(
  parameter int ENTRIES = 8,
  parameter int PORTS   = 2,
  parameter int ALLOC   = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ENTRIES-1:0]            busy,
  input  logic [ALLOC-1:0][ENTRIES-1:0] gnt,
  input  logic [PORTS-1:0][ENTRIES-1:0] cand,
  output logic [PORTS-1:0][ENTRIES-1:0] pick
);
  logic [ENTRIES-1:0] older_q   [ENTRIES];
  logic [ENTRIES-1:0] older_nxt [ENTRIES];
  logic [ENTRIES-1:0] new_mask;

  always_comb begin
    new_mask = '0;
    for (int k = 0; k < ALLOC; k++) new_mask |= gnt[k];
  end

  // A written slot is younger than every resident slot and every lower lane
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      logic [ENTRIES-1:0] lower;
      lower = '0;
      older_nxt[i] = older_q[i] & ~new_mask;
      for (int k = 0; k < ALLOC; k++) begin
        if (gnt[k][i]) older_nxt[i] = busy | lower;
        lower |= gnt[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) older_q[i] <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) older_q[i] <= older_nxt[i];
    end
  end

  // A candidate wins when no older candidate competes on its port
  always_comb begin
    for (int p = 0; p < PORTS; p++) begin
      for (int i = 0; i < ENTRIES; i++) begin
        pick[p][i] = cand[p][i] && ((cand[p] & older_q[i]) == '0);
      end
    end
  end
endmodule

// File: rtl/rs_wakeup_select.sv
module rs_wakeup_select #(
  parameter int ENTRIES = rs_pkg::RS_ENTRIES,
  parameter int ALLOC   = rs_pkg::RS_ALLOC,
  parameter int PORTS   = rs_pkg::RS_PORTS,
  parameter int NBC     = rs_pkg::RS_NBC,
  parameter int DW      = rs_pkg::RS_DW,
  parameter int TAGW    = rs_pkg::RS_TAGW,
  parameter int OPW     = rs_pkg::RS_OPW,
  parameter int ROBW    = rs_pkg::RS_ROBW,
  localparam int CLSW   = rs_pkg::cls_width(PORTS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        flush,
  input  logic [ALLOC-1:0]            alloc_vld,
  input  logic [ALLOC-1:0][OPW-1:0]   alloc_op,
  input  logic [ALLOC-1:0][CLSW-1:0]  alloc_cls,
  input  logic [ALLOC-1:0][ROBW-1:0]  alloc_rob,
  input  logic [ALLOC-1:0]            alloc_a_rdy,
  input  logic [ALLOC-1:0][TAGW-1:0]  alloc_a_tag,
  input  logic [ALLOC-1:0][DW-1:0]    alloc_a_val,
  input  logic [ALLOC-1:0]            alloc_b_rdy,
  input  logic [ALLOC-1:0][TAGW-1:0]  alloc_b_tag,
  input  logic [ALLOC-1:0][DW-1:0]    alloc_b_val,
  output logic                        alloc_rdy,
  input  logic [NBC-1:0]              res_vld,
  input  logic [NBC-1:0][TAGW-1:0]    res_tag,
  input  logic [NBC-1:0][DW-1:0]      res_val,
  output logic [PORTS-1:0]            iss_vld,
  output logic [PORTS-1:0][OPW-1:0]   iss_op,
  output logic [PORTS-1:0][DW-1:0]    iss_src_a,
  output logic [PORTS-1:0][DW-1:0]    iss_src_b,
  output logic [PORTS-1:0][ROBW-1:0]  iss_rob
);
  // Slot state
  logic [ENTRIES-1:0]  e_vld, e_a_rdy, e_b_rdy;
  logic [OPW-1:0]      e_op    [ENTRIES];
  logic [CLSW-1:0]     e_cls   [ENTRIES];
  logic [ROBW-1:0]     e_rob   [ENTRIES];
  logic [TAGW-1:0]     e_a_tag [ENTRIES];
  logic [TAGW-1:0]     e_b_tag [ENTRIES];
  logic [DW-1:0]       e_a_val [ENTRIES];
  logic [DW-1:0]       e_b_val [ENTRIES];

  // Named internal events
  logic [ALLOC-1:0][ENTRIES-1:0] lane_gnt;
  logic [ENTRIES-1:0]            alloc_fire;
  logic [ENTRIES-1:0]            issue_fire;
  logic [ENTRIES-1:0]            wake_a, wake_b;
  logic [PORTS-1:0][ENTRIES-1:0] cand, pick;

  // Incoming sources after same-cycle broadcast match
  logic [ALLOC-1:0]          s_a_rdy, s_b_rdy;
  logic [ALLOC-1:0][DW-1:0]  s_a_val, s_b_val;

  // Resident sources after broadcast match
  logic [ENTRIES-1:0]        w_a_rdy, w_b_rdy;
  logic [DW-1:0]             w_a_val [ENTRIES];
  logic [DW-1:0]             w_b_val [ENTRIES];

  rs_alloc_pick #(.ENTRIES(ENTRIES), .ALLOC(ALLOC)) u_alloc (
    .busy      (e_vld),
    .req       (alloc_vld),
    .block     (flush),
    .alloc_rdy (alloc_rdy),
    .gnt       (lane_gnt)
  );

  always_comb begin
    alloc_fire = '0;
    for (int k = 0; k < ALLOC; k++) alloc_fire |= lane_gnt[k];
  end

  generate
    for (genvar k = 0; k < ALLOC; k++) begin : g_lane
      rs_capture #(.NBC(NBC), .TAGW(TAGW), .DW(DW)) u_cap_a (
        .in_rdy (alloc_a_rdy[k]), .in_tag (alloc_a_tag[k]), .in_val (alloc_a_val[k]),
        .bc_vld (res_vld), .bc_tag (res_tag), .bc_val (res_val),
        .out_rdy(s_a_rdy[k]), .out_val(s_a_val[k])
      );
      rs_capture #(.NBC(NBC), .TAGW(TAGW), .DW(DW)) u_cap_b (
        .in_rdy (alloc_b_rdy[k]), .in_tag (alloc_b_tag[k]), .in_val (alloc_b_val[k]),
        .bc_vld (res_vld), .bc_tag (res_tag), .bc_val (res_val),
        .out_rdy(s_b_rdy[k]), .out_val(s_b_val[k])
      );
    end

    for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
      rs_capture #(.NBC(NBC), .TAGW(TAGW), .DW(DW)) u_wake_a (
        .in_rdy (e_a_rdy[e]), .in_tag (e_a_tag[e]), .in_val (e_a_val[e]),
        .bc_vld (res_vld), .bc_tag (res_tag), .bc_val (res_val),
        .out_rdy(w_a_rdy[e]), .out_val(w_a_val[e])
      );
      rs_capture #(.NBC(NBC), .TAGW(TAGW), .DW(DW)) u_wake_b (
        .in_rdy (e_b_rdy[e]), .in_tag (e_b_tag[e]), .in_val (e_b_val[e]),
        .bc_vld (res_vld), .bc_tag (res_tag), .bc_val (res_val),
        .out_rdy(w_b_rdy[e]), .out_val(w_b_val[e])
      );
    end
  endgenerate

  assign wake_a = e_vld & w_a_rdy & ~e_a_rdy;
  assign wake_b = e_vld & w_b_rdy & ~e_b_rdy;

  // Ready slots sorted into their port class
  always_comb begin
    for (int p = 0; p < PORTS; p++) begin
      for (int e = 0; e < ENTRIES; e++) begin
        cand[p][e] = e_vld[e] && e_a_rdy[e] && e_b_rdy[e] && (e_cls[e] == CLSW'(p));
      end
    end
  end

  rs_age_pick #(.ENTRIES(ENTRIES), .PORTS(PORTS), .ALLOC(ALLOC)) u_age (
    .clk   (clk),
    .rst_n (rst_n),
    .busy  (e_vld),
    .gnt   (lane_gnt),
    .cand  (cand),
    .pick  (pick)
  );

  // Issue multiplexers (one-hot OR)
  always_comb begin
    issue_fire = '0;
    for (int p = 0; p < PORTS; p++) begin
      iss_vld[p]   = |pick[p];
      iss_op[p]    = '0;
      iss_src_a[p] = '0;
      iss_src_b[p] = '0;
      iss_rob[p]   = '0;
      issue_fire  |= pick[p];
      for (int e = 0; e < ENTRIES; e++) begin
        if (pick[p][e]) begin
          iss_op[p]    |= e_op[e];
          iss_src_a[p] |= e_a_val[e];
          iss_src_b[p] |= e_b_val[e];
          iss_rob[p]   |= e_rob[e];
        end
      end
    end
  end

  // Control state: occupancy and ready flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_vld   <= '0;
      e_a_rdy <= '0;
      e_b_rdy <= '0;
    end else if (flush) begin
      e_vld <= '0;
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (alloc_fire[e]) begin
          e_vld[e] <= 1'b1;
          for (int k = 0; k < ALLOC; k++) begin
            if (lane_gnt[k][e]) begin
              e_a_rdy[e] <= s_a_rdy[k];
              e_b_rdy[e] <= s_b_rdy[k];
            end
          end
        end else if (e_vld[e]) begin
          e_a_rdy[e] <= w_a_rdy[e];
          e_b_rdy[e] <= w_b_rdy[e];
          if (issue_fire[e]) e_vld[e] <= 1'b0;
        end
      end
    end
  end

  // Payload state: no reset needed
  always_ff @(posedge clk) begin
    for (int e = 0; e < ENTRIES; e++) begin
      if (alloc_fire[e]) begin
        for (int k = 0; k < ALLOC; k++) begin
          if (lane_gnt[k][e]) begin
            e_op[e]    <= alloc_op[k];
            e_cls[e]   <= alloc_cls[k];
            e_rob[e]   <= alloc_rob[k];
            e_a_tag[e] <= alloc_a_tag[k];
            e_b_tag[e] <= alloc_b_tag[k];
            e_a_val[e] <= s_a_val[k];
            e_b_val[e] <= s_b_val[k];
          end
        end
      end else if (e_vld[e]) begin
        e_a_val[e] <= w_a_val[e];
        e_b_val[e] <= w_b_val[e];
      end
    end
  end
endmodule

// File: rtl/rs_wakeup_select_chk.sv
module rs_wakeup_select_chk #(
  parameter int ENTRIES = 8,
  parameter int PORTS   = 2,
  parameter int ALLOC   = 3
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          flush,
  input logic [ENTRIES-1:0]            e_vld,
  input logic [ENTRIES-1:0]            e_a_rdy,
  input logic [ENTRIES-1:0]            e_b_rdy,
  input logic [ENTRIES-1:0]            alloc_fire,
  input logic [ENTRIES-1:0]            issue_fire,
  input logic [ENTRIES-1:0]            wake_a,
  input logic [ENTRIES-1:0]            wake_b,
  input logic [PORTS-1:0][ENTRIES-1:0] pick
);
  // R9
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (e_vld == '0));

  // R2
  alloc_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|alloc_fire) |-> ($countones(~e_vld) >= ALLOC));

  generate
    for (genvar p = 0; p < PORTS; p++) begin : g_port
      // R8
      one_grant_per_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pick[p]));
    end

    for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
      logic [PORTS-1:0] col;
      always_comb for (int p = 0; p < PORTS; p++) col[p] = pick[p][e];

      // R7
      single_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(col));

      // R8
      issued_leaves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_fire[e] |=> !e_vld[e]);

      // R3
      issue_needs_operands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_fire[e] |-> (e_vld[e] && e_a_rdy[e] && e_b_rdy[e]));

      // R2
      no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_fire[e] |-> !e_vld[e]);

      // R4
      wake_a_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_a[e] && !flush) |=> e_a_rdy[e]);

      // R4
      wake_b_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_b[e] && !flush) |=> e_b_rdy[e]);
    end
  endgenerate
endmodule

bind rs_wakeup_select rs_wakeup_select_chk #(
  .ENTRIES(ENTRIES), .PORTS(PORTS), .ALLOC(ALLOC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flush      (flush),
  .e_vld      (e_vld),
  .e_a_rdy    (e_a_rdy),
  .e_b_rdy    (e_b_rdy),
  .alloc_fire (alloc_fire),
  .issue_fire (issue_fire),
  .wake_a     (wake_a),
  .wake_b     (wake_b),
  .pick       (pick)
);

// File: tb/rs_wakeup_select_tb.sv
module rs_wakeup_select_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int E  = 8;
  localparam int A  = 3;
  localparam int P  = 2;
  localparam int NB = 2;
  localparam int DW = 16;
  localparam int TW = 5;
  localparam int OW = 4;
  localparam int RW = 5;
  localparam int CW = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush;
  logic [A-1:0]          alloc_vld;
  logic [A-1:0][OW-1:0]  alloc_op;
  logic [A-1:0][CW-1:0]  alloc_cls;
  logic [A-1:0][RW-1:0]  alloc_rob;
  logic [A-1:0]          alloc_a_rdy, alloc_b_rdy;
  logic [A-1:0][TW-1:0]  alloc_a_tag, alloc_b_tag;
  logic [A-1:0][DW-1:0]  alloc_a_val, alloc_b_val;
  logic                  alloc_rdy;
  logic [NB-1:0]         res_vld;
  logic [NB-1:0][TW-1:0] res_tag;
  logic [NB-1:0][DW-1:0] res_val;
  logic [P-1:0]          iss_vld;
  logic [P-1:0][OW-1:0]  iss_op;
  logic [P-1:0][DW-1:0]  iss_src_a, iss_src_b;
  logic [P-1:0][RW-1:0]  iss_rob;

  always #(CLK_PERIOD/2) clk = ~clk;

  rs_wakeup_select dut_i (.*);

  int total = 0;
  int fails = 0;
  int seq_ctr = 0;

  // Bench model of waiting operations, ordered by sequence number
  bit            m_vld [E];
  int            m_seq [E];
  logic [OW-1:0] m_op  [E];
  int            m_cls [E];
  logic [RW-1:0] m_rob [E];
  bit            m_ar [E], m_br [E];
  logic [TW-1:0] m_at [E], m_bt [E];
  logic [DW-1:0] m_av [E], m_bv [E];

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int occupancy();
    int n = 0;
    for (int i = 0; i < E; i++) if (m_vld[i]) n++;
    return n;
  endfunction

  function automatic int oldest_ready(int p);
    int best = -1;
    for (int i = 0; i < E; i++)
      if (m_vld[i] && m_ar[i] && m_br[i] && m_cls[i] == p)
        if (best < 0 || m_seq[i] < m_seq[best]) best = i;
    return best;
  endfunction

  task automatic check_outputs(string req);
    bit exp_rdy;
    exp_rdy = (E - occupancy()) >= A;
    chk(alloc_rdy === exp_rdy, req, "alloc_rdy", 64'(alloc_rdy), 64'(exp_rdy));
    for (int p = 0; p < P; p++) begin
      int b;
      b = oldest_ready(p);
      if (b < 0) begin
        chk(iss_vld[p] === 1'b0, req, $sformatf("iss_vld[%0d]", p), 64'(iss_vld[p]), 64'd0);
      end else begin
        chk(iss_vld[p] === 1'b1 &&
            {iss_op[p], iss_src_a[p], iss_src_b[p], iss_rob[p]} ===
            {m_op[b], m_av[b], m_bv[b], m_rob[b]},
            req, $sformatf("issue[%0d]", p),
            64'({iss_vld[p], iss_op[p], iss_src_a[p], iss_src_b[p], iss_rob[p]}),
            64'({1'b1, m_op[b], m_av[b], m_bv[b], m_rob[b]}));
      end
    end
  endtask

  task automatic model_update();
    bit room;
    int gone [P];
    if (flush) begin
      for (int i = 0; i < E; i++) m_vld[i] = 0;
      return;
    end
    room = (E - occupancy()) >= A;
    for (int p = 0; p < P; p++) gone[p] = oldest_ready(p);
    for (int p = 0; p < P; p++) if (gone[p] >= 0) m_vld[gone[p]] = 0;
    for (int i = 0; i < E; i++) begin
      if (m_vld[i]) begin
        for (int b = 0; b < NB; b++) begin
          if (res_vld[b] && !m_ar[i] && m_at[i] == res_tag[b]) begin m_ar[i] = 1; m_av[i] = res_val[b]; end
          if (res_vld[b] && !m_br[i] && m_bt[i] == res_tag[b]) begin m_br[i] = 1; m_bv[i] = res_val[b]; end
        end
      end
    end
    if (room) begin
      for (int k = 0; k < A; k++) begin
        if (alloc_vld[k]) begin
          int s;
          s = -1;
          for (int i = 0; i < E; i++) if (!m_vld[i] && s < 0) s = i;
          m_vld[s] = 1; m_seq[s] = seq_ctr; seq_ctr++;
          m_op[s] = alloc_op[k]; m_cls[s] = int'(alloc_cls[k]); m_rob[s] = alloc_rob[k];
          m_ar[s] = alloc_a_rdy[k]; m_at[s] = alloc_a_tag[k]; m_av[s] = alloc_a_val[k];
          m_br[s] = alloc_b_rdy[k]; m_bt[s] = alloc_b_tag[k]; m_bv[s] = alloc_b_val[k];
          for (int b = 0; b < NB; b++) begin
            if (res_vld[b] && !m_ar[s] && m_at[s] == res_tag[b]) begin m_ar[s] = 1; m_av[s] = res_val[b]; end
            if (res_vld[b] && !m_br[s] && m_bt[s] == res_tag[b]) begin m_br[s] = 1; m_bv[s] = res_val[b]; end
          end
        end
      end
    end
  endtask

  // Check current outputs, account the driven inputs, advance one cycle
  task automatic step(string req);
    check_outputs(req);
    model_update();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_inputs();
    flush = 0; alloc_vld = '0; alloc_op = '0; alloc_cls = '0; alloc_rob = '0;
    alloc_a_rdy = '0; alloc_a_tag = '0; alloc_a_val = '0;
    alloc_b_rdy = '0; alloc_b_tag = '0; alloc_b_val = '0;
    res_vld = '0; res_tag = '0; res_val = '0;
  endtask

  task automatic set_alloc(int k, int op, int cls, int rob,
                           bit ar, int at, int av, bit br, int bt, int bv);
    alloc_vld[k] = 1'b1; alloc_op[k] = OW'(op); alloc_cls[k] = CW'(cls); alloc_rob[k] = RW'(rob);
    alloc_a_rdy[k] = ar; alloc_a_tag[k] = TW'(at); alloc_a_val[k] = DW'(av);
    alloc_b_rdy[k] = br; alloc_b_tag[k] = TW'(bt); alloc_b_val[k] = DW'(bv);
  endtask

  task automatic set_bus(int b, int tag, int val);
    res_vld[b] = 1'b1; res_tag[b] = TW'(tag); res_val[b] = DW'(val);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < E; i++) m_vld[i] = 0;
    clear_inputs();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: empty after reset
    step("R1");

    // R3: ready at write, issues next cycle
    set_alloc(0, 1, 0, 3, 1, 0, 16'h1111, 1, 0, 16'h2222);
    step("R3"); clear_inputs();
    step("R3");

    // R5: broadcast in the write cycle
    set_alloc(0, 2, 0, 4, 0, 3, 0, 1, 0, 16'h0B0B);
    set_bus(0, 3, 16'hABCD);
    step("R5"); clear_inputs();
    step("R5");

    // R4 and R11: wait, unrelated tag, then matching tag
    set_alloc(0, 3, 0, 5, 0, 4, 0, 1, 0, 16'h0C0C);
    step("R4"); clear_inputs();
    set_bus(1, 5, 16'hDEAD);
    step("R11"); clear_inputs();
    step("R11");
    set_bus(1, 4, 16'hBEEF);
    step("R4"); clear_inputs();
    step("R4");

    // R10: both buses wake one slot
    set_alloc(0, 4, 1, 6, 0, 1, 0, 0, 2, 0);
    step("R10"); clear_inputs();
    set_bus(0, 1, 16'h1234); set_bus(1, 2, 16'h5678);
    step("R10"); clear_inputs();
    step("R10");

    // R6: three lanes ready together drain in lane order
    set_alloc(0, 5, 0, 7, 1, 0, 16'h0005, 1, 0, 16'h0050);
    set_alloc(1, 6, 0, 8, 1, 0, 16'h0006, 1, 0, 16'h0060);
    set_alloc(2, 7, 0, 9, 1, 0, 16'h0007, 1, 0, 16'h0070);
    step("R6"); clear_inputs();
    repeat (4) step("R6");

    // R6: older slot woken together with younger one wins
    set_alloc(0, 8, 0, 10, 0, 6, 0, 1, 0, 16'h0080);
    step("R6"); clear_inputs();
    set_alloc(0, 9, 0, 11, 0, 7, 0, 1, 0, 16'h0090);
    step("R6"); clear_inputs();
    set_bus(0, 7, 16'h7777); set_bus(1, 6, 16'h6666);
    step("R6"); clear_inputs();
    repeat (3) step("R6");

    // R7: both classes in one cycle
    set_alloc(0, 10, 1, 12, 1, 0, 16'h00A1, 1, 0, 16'h00A2);
    set_alloc(1, 11, 0, 13, 1, 0, 16'h00B1, 1, 0, 16'h00B2);
    step("R7"); clear_inputs();
    repeat (2) step("R7");

    // R2: fill to two free slots, then a dropped request
    for (int g = 0; g < 2; g++) begin
      for (int k = 0; k < A; k++) set_alloc(k, 12, 0, 14 + k, 0, 9, 0, 1, 0, 0);
      step("R2"); clear_inputs();
    end
    set_alloc(0, 13, 1, 20, 1, 0, 16'h0D0D, 1, 0, 16'h0E0E);
    step("R2"); clear_inputs();
    repeat (2) step("R2");

    // R9: flush with a same-cycle request, then a tag that would have woken
    flush = 1;
    set_alloc(0, 14, 1, 21, 1, 0, 16'h0F0F, 1, 0, 16'h0F0F);
    step("R9"); clear_inputs();
    set_bus(0, 9, 16'h9999);
    step("R9"); clear_inputs();
    repeat (2) step("R9");

    // Random traffic: mixes wakeup, bypass, age order and back-pressure (R4 R5 R6 R7)
    for (int c = 0; c < 600; c++) begin
      int t0;
      clear_inputs();
      flush = ($urandom % 60) == 0;
      for (int k = 0; k < A; k++) begin
        if ($urandom % 2)
          set_alloc(k, $urandom % 16, $urandom % 2, $urandom % 32,
                    $urandom % 2, $urandom % 8, $urandom, $urandom % 2, $urandom % 8, $urandom);
      end
      t0 = $urandom % 8;
      if ($urandom % 10 < 6) set_bus(0, t0, $urandom);
      if ($urandom % 10 < 6) set_bus(1, (t0 + 1 + $urandom % 7) % 8, $urandom);
      step("R6");
    end
    clear_inputs();
    repeat (3) step("R8");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule